// File: doc/BRIEF.md
# Thread-Aggregating Event Counter Bank

This block holds a small bank of event counters for a processor core that runs several hardware threads. Each counter is one 32-bit register. The register packs three fields: an event selector, a per-thread enable mask and a 24-bit running count. Every cycle, each counter adds the number of enabled threads that pulse the selected event. Software therefore reads one total across the chosen threads. A few event codes are global: they sum the pulses of all threads, whatever the mask holds.

Event sources arrive as one pulse vector per thread. When the count wraps past its maximum, the counter raises its own sticky interrupt line. Software can preload the count to the negative of a sampling period, so the wrap comes after exactly that many events. Software acknowledges an interrupt by writing ones to a status register.

A build parameter selects a reduced legacy behaviour. In that mode a register write keeps the selector and mask but zeroes the count, and no interrupt is ever raised.

Top module: `evt_perf_bank`

## Requirements
- R1: After reset, every counter register and the status register read zero, and all interrupt lines are low.
- R2: Counter n is at bus address n (0 or 1) and the status register is at address 2. A counter register holds the event select in bits [31:28], the thread mask in bits [27:24] and the count in bits [23:0]. In the default mode, a write stores all 32 bits and a read returns them.
- R3: Each cycle, the count grows by the number of threads t that have mask bit t set and that pulse the selected event. The pulse for thread t and event e is input bit t*16+e. The count wraps modulo 2^24.
- R4: Pulses on event codes other than the selected one have no effect on the count. Pulses from threads whose mask bit is clear also have no effect.
- R5: Event codes 14 and 15 are global: they count the matching pulses of all threads, even when the mask is zero. Event code 0 is never global.
- R6: A counter whose top byte is zero (event 0, empty mask) keeps its count unchanged.
- R7: In the default mode, a count wrap raises that counter's own interrupt line. The line stays high until it is acknowledged, and the other counter's line is unaffected.
- R8: Status bits [1:0] read the interrupt lines of counters 0 and 1. Writing 1 to a status bit clears that line. Writing 0 leaves it unchanged.
- R9: A write to a counter in the same cycle as matching events stores exactly the written value; the events of that cycle are dropped.
- R10: In legacy mode, a counter write stores the select and mask but clears the count to zero. Counting then proceeds as in R3, and no interrupt line ever rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address: counters 0..1, status 2 |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| evt_pulse | input | 64 | Event pulses, bit t*16+e = thread t, event e |
| ovf_irq | output | 2 | Sticky overflow interrupt per counter |

## Verification
The main test sweeps all 256 pairs of event select and thread mask on counter 0, each under several cycles of pseudo-random pulses on all 64 pulse inputs. The expected total is worked out by arithmetic: it adds up only the pulses of the selected event on enabled threads, or on all threads for the global codes. This pattern tells correct lane selection apart from wrong event indexing, a missing mask gate, or the global codes being ignored. A directed case pulses only unselected events and masked threads, and must leave the count unchanged.

The wrap cases use two preloads. A single-thread preload crosses the maximum one step at a time. A four-thread preload jumps past zero in one cycle. Together they separate the wrap and interrupt logic from the adder width. A write landing in the same cycle as events, and a second instance built in legacy mode, show the write-priority and count-clearing behaviour.

// File: rtl/evt_perf_pkg.sv
package evt_perf_pkg;
    localparam int unsigned CNT_W   = 24;
    localparam int unsigned THR_N   = 4;
    localparam int unsigned SEL_W   = 4;
    localparam int unsigned NUM_EVT = 1 << SEL_W;
    localparam int unsigned REG_W   = CNT_W + THR_N + SEL_W;
    localparam int unsigned PULSE_W = THR_N * NUM_EVT;
    localparam int unsigned INC_W   = $clog2(THR_N + 1);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [THR_N-1:0] mask;
        logic [CNT_W-1:0] cnt;
    } ctr_reg_t;
endpackage

// File: rtl/evt_perf_match.sv
module evt_perf_match
    import evt_perf_pkg::*;
#(
    parameter logic [NUM_EVT-1:0] GLOBAL_EVT = 16'hC000
) (
    input  logic [SEL_W-1:0]   ctr_sel,
    input  logic [THR_N-1:0]   ctr_mask,
    input  logic [PULSE_W-1:0] evt_pulse,
    output logic [INC_W-1:0]   inc
);
    logic glb;

    // Code 0 is forced non-global so an all-zero top byte always idles.
    always_comb begin
        glb = GLOBAL_EVT[ctr_sel] && (ctr_sel != '0);
        inc = '0;
        for (int t = 0; t < int'(THR_N); t++) begin
            if (evt_pulse[t * int'(NUM_EVT) + int'(ctr_sel)] && (ctr_mask[t] || glb)) begin
                inc = inc + INC_W'(1);
            end
        end
    end
endmodule

// File: rtl/evt_perf_ctr.sv
module evt_perf_ctr
    import evt_perf_pkg::*;
#(
    parameter bit LEGACY = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [INC_W-1:0] inc,
    output ctr_reg_t         reg_q,
    output logic             ovf
);
    typedef struct packed {
        ctr_reg_t r;
    } ctr_st_t;

    ctr_st_t          st_d, st_q;
    logic [CNT_W:0]   sum;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.r.cnt} + (CNT_W + 1)'(inc);
        ovf  = 1'b0;
        if (wr_en) begin
            st_d.r = ctr_reg_t'(wr_data);
            if (LEGACY) begin
                st_d.r.cnt = '0;
            end
        end else begin
            st_d.r.cnt = sum[CNT_W-1:0];
            ovf        = !LEGACY && sum[CNT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_q = st_q.r;

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (reg_q[REG_W-1:CNT_W] == $past(wr_data[REG_W-1:CNT_W])) &&
                  (reg_q.cnt == (LEGACY ? '0 : $past(wr_data[CNT_W-1:0])))); // R9

    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (CNT_W'(reg_q.cnt - $past(reg_q.cnt)) <= CNT_W'(THR_N))); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && reg_q.sel == '0 && reg_q.mask == '0) |=> $stable(reg_q)); // R6
endmodule

// File: rtl/evt_perf_bank.sv
module evt_perf_bank
    import evt_perf_pkg::*;
#(
    parameter int unsigned        NUM_CTR    = 2,
    parameter int unsigned        ADDR_W     = 2,
    parameter bit                 LEGACY     = 1'b0,
    parameter logic [NUM_EVT-1:0] GLOBAL_EVT = 16'hC000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_we,
    input  logic [REG_W-1:0]        bus_wdata,
    output logic [REG_W-1:0]        bus_rdata,
    input  logic [PULSE_W-1:0]      evt_pulse,
    output logic [NUM_CTR-1:0]      ovf_irq
);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_CTR);

    typedef struct packed {
        logic [NUM_CTR-1:0] irq;
    } bank_st_t;

    bank_st_t           st_d, st_q;
    ctr_reg_t           ctr_q [NUM_CTR];
    logic [NUM_CTR-1:0] ovf_vec;
    logic               ack_we;

    assign ack_we = bus_we && (bus_addr == STAT_ADDR);

    for (genvar i = 0; i < int'(NUM_CTR); i++) begin : g_ctr
        logic [INC_W-1:0] inc;
        logic             wr_en;

        assign wr_en = bus_we && (bus_addr == ADDR_W'(i));

        evt_perf_match #(.GLOBAL_EVT(GLOBAL_EVT)) u_match (
            .ctr_sel   (ctr_q[i].sel),
            .ctr_mask  (ctr_q[i].mask),
            .evt_pulse (evt_pulse),
            .inc       (inc)
        );

        evt_perf_ctr #(.LEGACY(LEGACY)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_data (bus_wdata),
            .inc     (inc),
            .reg_q   (ctr_q[i]),
            .ovf     (ovf_vec[i])
        );

        AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovf_irq[i]) |-> $past(ovf_vec[i])); // R7

        AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_irq[i] && !(ack_we && bus_wdata[i])) |=> ovf_irq[i]); // R7

        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_we && bus_wdata[i] && !ovf_vec[i]) |=> !ovf_irq[i]); // R8
    end

    // A wrap in the acknowledge cycle wins over the clear.
    always_comb begin
        st_d = st_q;
        if (ack_we) begin
            st_d.irq = st_q.irq & ~bus_wdata[NUM_CTR-1:0];
        end
        st_d.irq = st_d.irq | ovf_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < int'(NUM_CTR); i++) begin
            if (bus_addr == ADDR_W'(i)) begin
                bus_rdata = ctr_q[i];
            end
        end
        if (bus_addr == STAT_ADDR) begin
            bus_rdata = REG_W'(st_q.irq);
        end
    end

    assign ovf_irq = st_q.irq;

    AST_LEGACY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        LEGACY |-> (ovf_irq == '0)); // R10
endmodule

// File: tb/sim_evt_perf_bank.sv
module sim_evt_perf_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = '0, l_addr = '0;
    logic        we = 1'b0, l_we = 1'b0;
    logic [31:0] wdata = '0, l_wdata = '0;
    logic [31:0] rdata, l_rdata;
    logic [63:0] pulse = '0;
    logic [1:0]  irq, l_irq;
    logic [63:0] rng = 64'h9E3779B97F4A7C15;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    evt_perf_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .evt_pulse(pulse), .ovf_irq(irq)
    );

    evt_perf_bank #(.LEGACY(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(l_addr), .bus_we(l_we),
        .bus_wdata(l_wdata), .bus_rdata(l_rdata), .evt_pulse(pulse), .ovf_irq(l_irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        tick();
        we = 1'b0;
    endtask

    task automatic wr_l(input logic [1:0] a, input logic [31:0] d);
        l_addr = a; l_wdata = d; l_we = 1'b1;
        tick();
        l_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step_rng();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
    endtask

    function automatic int expect_inc(input int s, input int m, input logic [63:0] p);
        int n = 0;
        for (int t = 0; t < 4; t++) begin
            if (p[t*16 + s] && (m[t] || s >= 14)) n++;
        end
        return n;
    endfunction

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            report();
        end
    end

    initial begin
        logic [31:0] v;
        logic [23:0] exp_cnt;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        rd(2'd0, v); check("R1 ctr0", v, 32'h0);
        rd(2'd1, v); check("R1 ctr1", v, 32'h0);
        rd(2'd2, v); check("R1 status", v, 32'h0);
        check("R1 irq", {30'h0, irq}, 32'h0);

        // R2: full register readback
        wr(2'd0, 32'h7A123456);
        rd(2'd0, v); check("R2 readback", v, 32'h7A123456);

        // R6 setup: counter 1 idle with a held value
        wr(2'd1, 32'h00ABCDEF);

        // R3 / R5: sweep every select and mask under random pulses
        for (int s = 0; s < 16; s++) begin
            for (int m = 0; m < 16; m++) begin
                wr(2'd0, {4'(s), 4'(m), 24'h000100});
                exp_cnt = 24'h000100;
                for (int c = 0; c < 4; c++) begin
                    step_rng();
                    pulse = rng;
                    exp_cnt = exp_cnt + 24'(expect_inc(s, m, rng));
                    tick();
                end
                pulse = '0;
                rd(2'd0, v);
                check(s >= 14 ? "R5 global sweep" : "R3 sweep", v, {4'(s), 4'(m), exp_cnt});
            end
        end

        // R6: idle counter held through the whole sweep
        rd(2'd1, v); check("R6 idle hold", v, 32'h00ABCDEF);

        // R4: only other events and masked threads pulse
        wr(2'd0, {4'd2, 4'b0101, 24'h000040});
        pulse = '0;
        for (int t = 0; t < 4; t++) pulse[t*16 + 3] = 1'b1;
        pulse[1*16 + 2] = 1'b1;
        pulse[3*16 + 2] = 1'b1;
        repeat (3) tick();
        pulse = '0;
        rd(2'd0, v); check("R4 ignored", v, {4'd2, 4'b0101, 24'h000040});

        // R7: single-step wrap on counter 0
        wr(2'd0, {4'd1, 4'b0001, 24'hFFFFFE});
        pulse = 64'h2;
        tick();
        pulse = '0;
        check("R7 no irq before wrap", {30'h0, irq}, 32'h0);
        rd(2'd0, v); check("R3 at max", v, {4'd1, 4'b0001, 24'hFFFFFF});
        pulse = 64'h2;
        tick();
        pulse = '0;
        rd(2'd0, v); check("R3 wrap to zero", v, {4'd1, 4'b0001, 24'h000000});
        check("R7 irq0 only", {30'h0, irq}, 32'h1);
        rd(2'd2, v); check("R8 status read", v, 32'h1);
        repeat (3) tick();
        check("R7 sticky", {30'h0, irq}, 32'h1);
        wr(2'd2, 32'h0);
        check("R8 write zero keeps", {30'h0, irq}, 32'h1);
        wr(2'd2, 32'h1);
        check("R8 write one clears", {30'h0, irq}, 32'h0);

        // R7: four-thread jump past zero on counter 1
        wr(2'd1, {4'd5, 4'hF, 24'hFFFFFE});
        pulse = '0;
        for (int t = 0; t < 4; t++) pulse[t*16 + 5] = 1'b1;
        tick();
        pulse = '0;
        rd(2'd1, v); check("R3 multi-thread wrap", v, {4'd5, 4'hF, 24'h000002});
        check("R7 irq1 only", {30'h0, irq}, 32'h2);
        wr(2'd2, 32'h2);
        check("R8 clear irq1", {30'h0, irq}, 32'h0);

        // R9: write collides with events
        wr(2'd0, {4'd1, 4'hF, 24'h000010});
        pulse = '0;
        for (int t = 0; t < 4; t++) pulse[t*16 + 1] = 1'b1;
        wr(2'd0, {4'd1, 4'hF, 24'h000500});
        pulse = '0;
        rd(2'd0, v); check("R9 write wins", v, {4'd1, 4'hF, 24'h000500});

        // R10: legacy instance
        wr_l(2'd0, {4'd1, 4'h1, 24'h123456});
        l_addr = 2'd0; #1;
        check("R10 write clears count", l_rdata, {4'd1, 4'h1, 24'h0});
        pulse = 64'h2;
        repeat (3) tick();
        pulse = '0;
        l_addr = 2'd0; #1;
        check("R10 legacy counts", l_rdata, {4'd1, 4'h1, 24'h3});
        check("R10 no irq", {30'h0, l_irq}, 32'h0);

        done = 1'b1;
        report();
    end
endmodule